// File: doc/BRIEF.md
# Hart Wait-State Step Controller

This block decides the outcome of one execution step for a single hart that is either running (Active) or parked on a wait-for-interrupt style instruction (Waiting). Each step request carries the conditions of that step: whether an interrupt is pending, whether the environment asks a parked hart to leave its wait, the current privilege, the timeout-wait control bit, a configuration bit that turns wait instructions into no-ops, the counter increment enable, and, for a running hart, the kind and 32-bit encoding of the instruction just executed. The block returns the hart state at the end of the step, whether a step counted, whether an instruction retired, and whether an illegal-instruction exception (with its trap value) occurred. It also keeps the 64-bit retired-instruction counter.

A parked wait instruction is not finished when it executes. It is finished on a later step: it retires when an interrupt arrives, and when it is told to leave its wait it either retires or becomes an illegal-instruction exception, depending on privilege and the timeout-wait bit. The saved encoding of the parked instruction provides the trap value for that exception.

The step request is a valid/ready input. `step_ready` is tied high, so the caller is never stalled and every cycle with `step_valid` high is one accepted step. The result appears on the registered outputs on the next clock edge and is marked by `res_valid`. The result has no back-pressure: it is only valid for that one cycle, and the caller must take it then.

Top module: `hart_step_ctrl`

## Requirements
- R1: After reset the hart is Active (`hart_waiting`=0), `saved_bits` is 0, `instret` is 0, and `res_valid` is 0.
- R2: `step_ready` is always 1. `res_valid` is 1 in the cycle after each accepted step and 0 otherwise. With no accepted step, the state, `saved_bits` and `instret` do not change.
- R3: A Waiting hart that sees `irq_pending`=1 returns to Active and retires the parked instruction. It does not service the interrupt in that step (`irq_taken`=0).
- R4: A Waiting hart with no pending interrupt and `exit_wait`=1 returns to Active. The parked instruction retires when `priv`=2'b11 (Machine) or `tw`=0. Otherwise it raises an illegal-instruction exception and does not retire.
- R5: A Waiting hart with no pending interrupt and `exit_wait`=0 stays Waiting, reports `stepped`=0 and `retired`=0, and keeps `saved_bits`. The op fields are ignored in this case.
- R6: In Active with no pending interrupt, a wait instruction (`op_kind`=2'd1) with `wfi_nop`=1 retires at once and the hart stays Active.
- R7: In Active, a wait instruction with `wfi_nop`=0 moves the hart to Waiting, stores `op_bits` into `saved_bits`, and reports `stepped`=0. This holds even when `exit_wait`=1 in the same step.
- R8: `stepped` is 1 exactly when the hart is Active at the end of the step.
- R9: `instret` increases by exactly 1 when the step ends Active, an instruction retired, and `inc_en`=1 at that step. Otherwise it holds.
- R10: For an illegal-instruction exception with `tval_en`=1, `tval_valid`=1 and `tval` is the offending 32-bit encoding zero-extended to XLEN. With `tval_en`=0, `tval_valid`=0 and `tval`=0.
- R11: In Active, `irq_pending`=1 takes the interrupt (`irq_taken`=1, `stepped`=1, `retired`=0). The instruction fields are ignored.
- R12: In Active with no interrupt, `op_kind` selects the outcome: 2'd0 retires, 2'd2 is a non-illegal trap (no retire, no illegal flag), and 2'd3 is an illegal instruction whose trap value is `op_bits`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_valid | input | 1 | A step request is presented |
| step_ready | output | 1 | Always 1; each valid cycle is accepted |
| exit_wait | input | 1 | Ask a parked hart to leave its wait |
| irq_pending | input | 1 | An enabled interrupt is pending |
| priv | input | 2 | Current privilege, 2'b11 = Machine |
| tw | input | 1 | Timeout-wait control bit |
| wfi_nop | input | 1 | Treat wait instructions as no-ops |
| inc_en | input | 1 | Counter increment enable for this step |
| tval_en | input | 1 | Report instruction bits as trap value |
| op_kind | input | 2 | Active-step outcome: 0 retire, 1 wait, 2 trap, 3 illegal |
| op_bits | input | 32 | Encoding of the executed instruction |
| res_valid | output | 1 | Step result is valid this cycle |
| hart_waiting | output | 1 | Hart state: 1 Waiting, 0 Active |
| stepped | output | 1 | The step counted (hart Active at end) |
| retired | output | 1 | An instruction retired in the step |
| illegal | output | 1 | Illegal-instruction exception in the step |
| irq_taken | output | 1 | Interrupt serviced in the step |
| tval_valid | output | 1 | `tval` carries a trap value |
| tval | output | 64 | Trap value, zero-extended instruction bits |
| saved_bits | output | 32 | Encoding of the parked instruction |
| instret | output | 64 | Retired-instruction counter |

## Verification
The assertions take for granted that the step fields are stable and meaningful in any cycle with `step_valid` high, and that `op_kind` is only read for an Active hart with no pending interrupt. The stimulus drives every input at the falling edge and holds it for a whole cycle. It only sets a wait encoding while the hart is Active, and it reaches every Waiting exit (interrupt, exit at Machine, exit with `tw`=0, exit with `tw`=1 at user privilege) from a freshly parked instruction with a distinct encoding. In this way each outcome traces back to exactly one saved value.

// File: rtl/hart_step_pkg.sv
package hart_step_pkg;
  localparam int INSN_W = 32;
  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  typedef enum logic [1:0] {
    OP_RETIRE  = 2'd0,
    OP_WAIT    = 2'd1,
    OP_TRAP    = 2'd2,
    OP_ILLEGAL = 2'd3
  } op_kind_e;

  typedef struct packed {
    logic              next_wait;
    logic              save_en;
    logic              retire;
    logic              illegal;
    logic              irq_take;
    logic [INSN_W-1:0] ill_bits;
  } step_dec_t;
endpackage

// File: rtl/hart_step_decide.sv
module hart_step_decide
  import hart_step_pkg::*;
(
  input  logic              waiting,
  input  logic [INSN_W-1:0] saved,
  input  logic              exit_wait,
  input  logic              irq_pending,
  input  logic [1:0]        priv,
  input  logic              tw,
  input  logic              wfi_nop,
  input  logic [1:0]        op_kind,
  input  logic [INSN_W-1:0] op_bits,
  output step_dec_t         dec
);
  always_comb begin
    dec           = '0;
    dec.next_wait = waiting;
    dec.ill_bits  = saved;
    if (waiting) begin
      if (irq_pending) begin
        dec.next_wait = 1'b0;
        dec.retire    = 1'b1;
      end else if (exit_wait) begin
        dec.next_wait = 1'b0;
        if (priv == PRIV_MACHINE || !tw) dec.retire  = 1'b1;
        else                             dec.illegal = 1'b1;
      end
    end else if (irq_pending) begin
      dec.irq_take = 1'b1;
    end else begin
      unique case (op_kind_e'(op_kind))
        OP_RETIRE: dec.retire = 1'b1;
        OP_WAIT: begin
          if (wfi_nop) dec.retire = 1'b1;
          else begin
            dec.next_wait = 1'b1;
            dec.save_en   = 1'b1;
          end
        end
        OP_TRAP: ;
        OP_ILLEGAL: begin
          dec.illegal  = 1'b1;
          dec.ill_bits = op_bits;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hart_step_state.sv
module hart_step_state
  import hart_step_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              next_wait,
  input  logic              save_en,
  input  logic [INSN_W-1:0] save_bits,
  output logic              waiting,
  output logic [INSN_W-1:0] saved
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      saved   <= '0;
    end else if (fire) begin
      waiting <= next_wait;
      if (save_en) saved <= save_bits;
    end
  end

  // R5: parked encoding holds while the hart remains Waiting
  a_r5_saved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && next_wait) |=> $stable(saved));
  // R2: no accepted step, no state change
  a_r2_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(waiting) && $stable(saved)));
endmodule

// File: rtl/hart_step_counter.sv
module hart_step_counter #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bump,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (bump) count <= count + 1'b1;
  end

  // R9: counter moves by one only on a bump, never otherwise
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    bump |=> (count == $past(count) + 1'b1));
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bump |=> $stable(count));
endmodule

// File: rtl/hart_step_ctrl.sv
module hart_step_ctrl
  import hart_step_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int CW   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_valid,
  output logic              step_ready,
  input  logic              exit_wait,
  input  logic              irq_pending,
  input  logic [1:0]        priv,
  input  logic              tw,
  input  logic              wfi_nop,
  input  logic              inc_en,
  input  logic              tval_en,
  input  logic [1:0]        op_kind,
  input  logic [INSN_W-1:0] op_bits,
  output logic              res_valid,
  output logic              hart_waiting,
  output logic              stepped,
  output logic              retired,
  output logic              illegal,
  output logic              irq_taken,
  output logic              tval_valid,
  output logic [XLEN-1:0]   tval,
  output logic [INSN_W-1:0] saved_bits,
  output logic [CW-1:0]     instret
);
  localparam int PAD_W = XLEN - INSN_W;

  logic      fire;
  logic      bump;
  step_dec_t dec;

  assign step_ready = 1'b1;
  assign fire       = step_valid;

  hart_step_decide u_decide (
    .waiting    (hart_waiting),
    .saved      (saved_bits),
    .exit_wait  (exit_wait),
    .irq_pending(irq_pending),
    .priv       (priv),
    .tw         (tw),
    .wfi_nop    (wfi_nop),
    .op_kind    (op_kind),
    .op_bits    (op_bits),
    .dec        (dec)
  );

  hart_step_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .next_wait(dec.next_wait),
    .save_en  (dec.save_en),
    .save_bits(op_bits),
    .waiting  (hart_waiting),
    .saved    (saved_bits)
  );

  assign bump = fire && !dec.next_wait && dec.retire && inc_en;

  hart_step_counter #(.CW(CW)) u_count (
    .clk  (clk),
    .rst_n(rst_n),
    .bump (bump),
    .count(instret)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      stepped    <= 1'b0;
      retired    <= 1'b0;
      illegal    <= 1'b0;
      irq_taken  <= 1'b0;
      tval_valid <= 1'b0;
      tval       <= '0;
    end else begin
      res_valid  <= fire;
      stepped    <= fire && !dec.next_wait;
      retired    <= fire && dec.retire;
      illegal    <= fire && dec.illegal;
      irq_taken  <= fire && dec.irq_take;
      tval_valid <= fire && dec.illegal && tval_en;
      tval       <= (fire && dec.illegal && tval_en) ? {{PAD_W{1'b0}}, dec.ill_bits} : '0;
    end
  end

  // R2: one result cycle per accepted step
  a_r2_res_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> res_valid);
  a_r2_res_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !res_valid);
  // R3: interrupt wakes a parked hart and retires the parked instruction
  a_r3_irq_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hart_waiting && irq_pending) |=> (!hart_waiting && retired && !irq_taken));
  // R5: parked hart stays parked without interrupt or exit request
  a_r5_stay: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hart_waiting && !irq_pending && !exit_wait) |=> (hart_waiting && !stepped && !retired));
  // R7: a wait instruction parks even when exit_wait is set
  a_r7_park: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !hart_waiting && !irq_pending && op_kind == 2'd1 && !wfi_nop)
      |=> (hart_waiting && saved_bits == $past(op_bits)));
  // R8: a counted step means the hart ended Active
  a_r8_step_state: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (stepped != hart_waiting));
  // R10: trap value present only with an illegal exception
  a_r10_tval: assert property (@(posedge clk) disable iff (!rst_n)
    tval_valid |-> illegal);
endmodule

// File: tb/test_hart_step_ctrl.sv
module test_hart_step_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_valid = 1'b0, exit_wait = 1'b0, irq_pending = 1'b0;
  logic [1:0]  priv = 2'b11;
  logic        tw = 1'b0, wfi_nop = 1'b0, inc_en = 1'b1, tval_en = 1'b1;
  logic [1:0]  op_kind = 2'd0;
  logic [31:0] op_bits = '0;
  logic        step_ready, res_valid, hart_waiting, stepped, retired, illegal, irq_taken, tval_valid;
  logic [63:0] tval, instret;
  logic [31:0] saved_bits;

  int errors = 0;
  int checks = 0;
  logic [63:0] exp_cnt = '0;
  logic [31:0] exp_saved = '0;

  always #10 clk = ~clk;

  hart_step_ctrl i_hart_step_ctrl (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_ready(step_ready),
    .exit_wait(exit_wait), .irq_pending(irq_pending), .priv(priv), .tw(tw),
    .wfi_nop(wfi_nop), .inc_en(inc_en), .tval_en(tval_en), .op_kind(op_kind),
    .op_bits(op_bits), .res_valid(res_valid), .hart_waiting(hart_waiting),
    .stepped(stepped), .retired(retired), .illegal(illegal), .irq_taken(irq_taken),
    .tval_valid(tval_valid), .tval(tval), .saved_bits(saved_bits), .instret(instret)
  );

  typedef struct packed {
    logic        irq, ex;
    logic [1:0]  pr;
    logic        tw, nop, inc;
    logic [1:0]  kind;
    logic [31:0] bits;
    logic        e_wait, e_ret, e_ill, e_irq;
    logic [31:0] e_tval;
  } vec_t;

  function automatic vec_t mk(logic irq, logic ex, logic [1:0] pr, logic t, logic nop,
                              logic inc, logic [1:0] kind, logic [31:0] bits,
                              logic e_wait, logic e_ret, logic e_ill, logic e_irq,
                              logic [31:0] e_tval);
    return '{irq, ex, pr, t, nop, inc, kind, bits, e_wait, e_ret, e_ill, e_irq, e_tval};
  endfunction

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    mk(0,0,2'b11,0,0,1,2'd0,32'h0000_0013, 0,1,0,0,32'h0),          // R12 retire
    mk(0,0,2'b11,0,0,1,2'd2,32'h0000_0073, 0,0,0,0,32'h0),          // R12 trap
    mk(0,0,2'b11,0,0,1,2'd3,32'hAAAA_0001, 0,0,1,0,32'hAAAA_0001),  // R12 R10 illegal
    mk(1,0,2'b11,0,0,1,2'd0,32'h0,         0,0,0,1,32'h0),          // R11 irq
    mk(0,1,2'b11,0,0,1,2'd1,32'h1050_0073, 1,0,0,0,32'h0),          // R7 park with exit
    mk(0,0,2'b11,0,0,1,2'd0,32'h1234_5678, 1,0,0,0,32'h0),          // R5 stay
    mk(1,0,2'b00,1,0,1,2'd0,32'h0,         0,1,0,0,32'h0),          // R3 irq wake
    mk(0,0,2'b00,0,0,1,2'd1,32'h1111_0073, 1,0,0,0,32'h0),          // R7 park
    mk(0,1,2'b00,1,0,1,2'd0,32'h0,         0,0,1,0,32'h1111_0073),  // R4 illegal
    mk(0,0,2'b00,0,0,1,2'd1,32'h2222_0073, 1,0,0,0,32'h0),          // R7 park
    mk(0,1,2'b00,0,0,1,2'd0,32'h0,         0,1,0,0,32'h0),          // R4 tw=0
    mk(0,0,2'b00,0,0,1,2'd1,32'h3333_0073, 1,0,0,0,32'h0),          // R7 park
    mk(0,1,2'b11,1,0,1,2'd0,32'h0,         0,1,0,0,32'h0),          // R4 machine
    mk(0,1,2'b11,0,1,1,2'd1,32'h4444_0073, 0,1,0,0,32'h0),          // R6 nop
    mk(0,0,2'b11,0,0,0,2'd0,32'h0000_0013, 0,1,0,0,32'h0)           // R9 inc_en=0
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 waiting", {63'b0, hart_waiting}, 64'd0);
    chk("R1 saved", {32'b0, saved_bits}, 64'd0);
    chk("R1 instret", instret, 64'd0);
    chk("R1 res_valid", {63'b0, res_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 ready", {63'b0, step_ready}, 64'd1);

    for (int i = 0; i < NV; i++) begin
      step_valid = 1'b1;
      irq_pending = VT[i].irq; exit_wait = VT[i].ex; priv = VT[i].pr; tw = VT[i].tw;
      wfi_nop = VT[i].nop; inc_en = VT[i].inc; op_kind = VT[i].kind; op_bits = VT[i].bits;
      @(negedge clk);
      if (VT[i].e_wait && !hart_waiting) ;
      if (VT[i].kind == 2'd1 && VT[i].e_wait) exp_saved = VT[i].bits;
      if (!VT[i].e_wait && VT[i].e_ret && VT[i].inc) exp_cnt = exp_cnt + 1;
      chk("R2 res_valid", {63'b0, res_valid}, 64'd1);
      chk("R5 R7 waiting", {63'b0, hart_waiting}, {63'b0, VT[i].e_wait});
      chk("R8 stepped", {63'b0, stepped}, {63'b0, !VT[i].e_wait});
      chk("R3 R4 R6 R12 retired", {63'b0, retired}, {63'b0, VT[i].e_ret});
      chk("R4 R12 illegal", {63'b0, illegal}, {63'b0, VT[i].e_ill});
      chk("R11 irq_taken", {63'b0, irq_taken}, {63'b0, VT[i].e_irq});
      chk("R10 tval", tval, {32'b0, VT[i].e_tval});
      chk("R10 tval_valid", {63'b0, tval_valid}, {63'b0, VT[i].e_ill});
      chk("R9 instret", instret, exp_cnt);
      chk("R7 saved", {32'b0, saved_bits}, {32'b0, exp_saved});
    end

    // R2: idle cycle changes nothing
    step_valid = 1'b0; irq_pending = 1'b1; op_kind = 2'd1; op_bits = 32'h5555_0073;
    @(negedge clk);
    chk("R2 idle res_valid", {63'b0, res_valid}, 64'd0);
    chk("R2 idle waiting", {63'b0, hart_waiting}, 64'd0);
    chk("R2 idle instret", instret, exp_cnt);
    chk("R2 idle saved", {32'b0, saved_bits}, {32'b0, exp_saved});

    // R10 with tval_en=0: park, then exit at user privilege with tw=1
    step_valid = 1'b1; irq_pending = 1'b0; exit_wait = 1'b0; wfi_nop = 1'b0;
    priv = 2'b00; tw = 1'b1; tval_en = 1'b0; inc_en = 1'b1;
    op_kind = 2'd1; op_bits = 32'h6666_0073;
    @(negedge clk);
    chk("R7 park saved", {32'b0, saved_bits}, 64'h6666_0073);
    exit_wait = 1'b1; op_kind = 2'd0;
    @(negedge clk);
    chk("R4 illegal no tval_en", {63'b0, illegal}, 64'd1);
    chk("R10 tval_valid off", {63'b0, tval_valid}, 64'd0);
    chk("R10 tval off", tval, 64'd0);
    chk("R9 no count on illegal", instret, exp_cnt);

    // R9: irq wake with inc_en=0 retires but does not count
    exit_wait = 1'b0; op_kind = 2'd1; op_bits = 32'h7777_0073;
    @(negedge clk);
    irq_pending = 1'b1; inc_en = 1'b0;
    @(negedge clk);
    chk("R3 wake retired", {63'b0, retired}, 64'd1);
    chk("R9 inhibited", instret, exp_cnt);
    step_valid = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule